// File: doc/BRIEF.md
# Random Generator Command Controller

This block is the register front end of a random number generator. A host drives it over a simple 32-bit register bus with separate read and write strobes. It can ask the block to reseed its internal state, either by mixing in a seed word or by replacing the state with a nonce, and it can ask for a block of random output. Results are posted in eight 32-bit data words. A level interrupt reports completion and error events, gated by a global enable and by one enable per source.

A 64-bit linear feedback shift register, combined with a 64-bit seed input port, stands in for the entropy source and the deterministic generator core. The command engine rejects output requests until at least one reseed has finished. It also rejects any command that arrives while an earlier one is still running, and reports that as a lockup event. Both operations take a fixed number of cycles, so the host can either poll the status register or wait for the interrupt.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 except the two constant words, and `irq_o` is 0.
- R2: The feature word at 0x1C reads 0x0000000D: bit 3 = mission-mode reset, bit 2 = seed source present, and bits 1:0 = 1 for a 256-bit maximum. The build word at 0x68 reads 0x0000001C: bit 5 = 0 for no auto-reseed loopback, and bits 4, 3 and 2 = 1.
- R3: A generate command (value 1 written to 0x00) issued before the first reseed leaves the data words unchanged and sets the request-lockup event (interrupt status bit 3).
- R4: A reseed command, value 2 (mix) or value 3 (nonce), finishes 16 cycles after its write. It then sets status bit 9 at 0x04 (seeded) and interrupt status bit 1 (seed done). A mix reseed sets the state to state XOR `seed_i`; a nonce reseed sets it to `seed_i`.
- R5: A generate command finishes 8 cycles after its write and then sets interrupt status bit 0 (random ready).
- R6: A generate steps the state eight times, s' = {s[62:0], s[63]^s[62]^s[60]^s[59]}. After step k (0..7), data word k (at 0x20 + 4k) is loaded with s'[63:32] XOR s'[31:0]. The state after reset is 1.
- R7: Mode register bit 3 (0x08), sampled when a generate is accepted, selects 256-bit output (all eight words written) when 1. When it is 0, the output is 128-bit: words 4 to 7 keep their previous values, and the state still steps eight times.
- R8: A non-zero command written while an operation is running is dropped: it changes neither the result nor the seeded state. It sets request lockup.
- R9: Writing 1 to a bit of the interrupt status register (0x14) clears that bit. Writing 0 leaves the bit alone. An event that arrives in the same cycle wins over the clear.
- R10: `irq_o` = enable bit 31 AND OR over i of (enable bit i AND status bit i), for i = 0..4, using the enable register at 0x10.
- R11: A reseed whose new state would be zero loads 1 instead and sets interrupt status bit 4 (LFSR lockup).
- R12: The generate that completes the 4th output since the last reseed sets interrupt status bit 2 (age alarm). Earlier generates do not set it.
- R13: Command value 0 starts nothing and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; `rdata_o` is 0 when it is low |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from the address |
| seed_i | input | 64 | Seed word that is mixed into or loaded as the state |
| irq_o | output | 1 | Level interrupt |

## Verification
The generate path is tried with several seeds under both reseed kinds and both output widths. This separates a wrong mix, which gives state XOR seed, from a wrong load, which gives the seed alone. It also shows whether the upper four words are written in 128-bit mode. An all-zero nonce seed exercises the lockup substitute state. Commands written before seeding, while busy, and with value 0 separate a dropped command from one that is queued or acted on. The interrupt output is swept across the global and per-source enables against a single pending source, so a missing AND term is exposed.

// File: rtl/rng_cmd_pkg.sv
package rng_cmd_pkg;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NEV = 5;

  localparam logic [AW-1:0] OFS_CMD   = 8'h00;
  localparam logic [AW-1:0] OFS_STAT  = 8'h04;
  localparam logic [AW-1:0] OFS_MODE  = 8'h08;
  localparam logic [AW-1:0] OFS_IEN   = 8'h10;
  localparam logic [AW-1:0] OFS_IST   = 8'h14;
  localparam logic [AW-1:0] OFS_FEAT  = 8'h1C;
  localparam logic [AW-1:0] OFS_DATA  = 8'h20;
  localparam logic [AW-1:0] OFS_BUILD = 8'h68;

  localparam int STAT_SEEDED_BIT = 9;
  localparam int MODE_WIDE_BIT   = 3;
  localparam int IEN_GLOBAL_BIT  = 31;

  // event bit positions, shared by enable and status
  localparam int EV_RDY    = 0;
  localparam int EV_SEED   = 1;
  localparam int EV_AGE    = 2;
  localparam int EV_REQLK  = 3;
  localparam int EV_LFSRLK = 4;

  localparam logic [63:0] LFSR_INIT = 64'h1;

  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_GEN    = 2'd1,
    CMD_RESEED = 2'd2,
    CMD_NONCE  = 2'd3
  } cmd_e;
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr
  import rng_cmd_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int SW = 2 * WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          mix_i,
  input  logic          nonce_i,
  input  logic [SW-1:0] seed_i,
  output logic [WORD_W-1:0] word_o,
  output logic          zero_o
);
  logic [SW-1:0] state_q, nxt, cand;

  assign nxt    = {state_q[SW-2:0], state_q[SW-1] ^ state_q[SW-2] ^ state_q[SW-4] ^ state_q[SW-5]};
  assign word_o = nxt[SW-1:WORD_W] ^ nxt[WORD_W-1:0];
  assign cand   = nonce_i ? seed_i : (state_q ^ seed_i);
  assign zero_o = mix_i && (cand == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= SW'(LFSR_INIT);
    else if (mix_i)     state_q <= zero_o ? SW'(LFSR_INIT) : cand;
    else if (step_i)    state_q <= nxt;
  end
endmodule

// File: rtl/rng_seq.sv
module rng_seq
  import rng_cmd_pkg::*;
#(
  parameter int GEN_CYC   = 8,
  parameter int SEED_CYC  = 16,
  parameter int NWORDS    = 8,
  parameter int AGE_LIMIT = 4,
  localparam int MAXC  = (SEED_CYC > GEN_CYC) ? SEED_CYC : GEN_CYC,
  localparam int CW    = $clog2(MAXC) + 1,
  localparam int AGE_W = $clog2(AGE_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  cmd_e          cmd_i,
  input  logic          wide_i,
  output logic          step_o,
  output logic          load_o,
  output logic [CW-1:0] idx_o,
  output logic          gen_done_o,
  output logic          seed_done_o,
  output logic          nonce_o,
  output logic          lockup_o,
  output logic          age_o,
  output logic          seeded_o,
  output logic          busy_o
);
  localparam logic [CW-1:0] GEN_LAST  = CW'(GEN_CYC - 1);
  localparam logic [CW-1:0] SEED_LAST = CW'(SEED_CYC - 1);

  logic             busy_q, seeded_q, half_q, start, last;
  cmd_e             op_q;
  logic [CW-1:0]    cnt_q, nwords;
  logic [AGE_W-1:0] age_q;

  assign lockup_o    = cmd_we_i && (cmd_i != CMD_NOP) &&
                       (busy_q || (cmd_i == CMD_GEN && !seeded_q));
  assign start       = cmd_we_i && (cmd_i != CMD_NOP) && !lockup_o;
  assign last        = busy_q && (cnt_q == '0);
  assign step_o      = busy_q && (op_q == CMD_GEN);
  assign idx_o       = GEN_LAST - cnt_q;
  assign nwords      = half_q ? CW'(NWORDS / 2) : CW'(NWORDS);
  assign load_o      = step_o && (idx_o < nwords);
  assign gen_done_o  = last && (op_q == CMD_GEN);
  assign seed_done_o = last && (op_q != CMD_GEN);
  assign nonce_o     = op_q == CMD_NONCE;
  assign age_o       = gen_done_o && (age_q == AGE_W'(AGE_LIMIT - 1));
  assign seeded_o    = seeded_q;
  assign busy_o      = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= CMD_NOP;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      op_q   <= cmd_i;
      cnt_q  <= (cmd_i == CMD_GEN) ? GEN_LAST : SEED_LAST;
      half_q <= !wide_i;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seeded_q <= 1'b0;
      age_q    <= '0;
    end else if (seed_done_o) begin
      seeded_q <= 1'b1;
      age_q    <= '0;
    end else if (gen_done_o && age_q != AGE_W'(AGE_LIMIT)) begin
      age_q    <= age_q + 1'b1;
    end
  end
endmodule

// File: rtl/rng_irq.sv
module rng_irq
  import rng_cmd_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ien_we_i,
  input  logic           ist_we_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NEV-1:0] ev_i,
  output logic [DW-1:0]  ien_o,
  output logic [NEV-1:0] ist_o,
  output logic           irq_o
);
  localparam logic [DW-1:0] IEN_MASK = (DW'(1) << IEN_GLOBAL_BIT) | DW'((1 << NEV) - 1);

  logic [DW-1:0]  ien_q;
  logic [NEV-1:0] ist_q, clr;

  assign clr = ist_we_i ? wdata_i[NEV-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      if (ien_we_i) ien_q <= wdata_i & IEN_MASK;
      ist_q <= (ist_q & ~clr) | ev_i;
    end
  end

  assign ien_o = ien_q;
  assign ist_o = ist_q;
  assign irq_o = ien_q[IEN_GLOBAL_BIT] && |(ien_q[NEV-1:0] & ist_q);
endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
  import rng_cmd_pkg::*;
#(
  parameter int    NWORDS    = 8,
  parameter int    GEN_CYC   = 8,
  parameter int    SEED_CYC  = 16,
  parameter int    AGE_LIMIT = 4,
  parameter bit    MAX_WIDE  = 1'b1,
  localparam int   IW = $clog2(NWORDS),
  localparam int   MAXC = (SEED_CYC > GEN_CYC) ? SEED_CYC : GEN_CYC,
  localparam int   CW = $clog2(MAXC) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [63:0]   seed_i,
  output logic          irq_o
);
  localparam logic [DW-1:0] FEAT_WORD  = {28'd0, 1'b1, 1'b1, 1'b0, MAX_WIDE};
  localparam logic [DW-1:0] BUILD_WORD = {26'd0, 1'b0, 1'b1, 1'b1, MAX_WIDE, 2'b00};

  logic [DW-1:0]  data_q [NWORDS];
  logic [DW-1:0]  ien_rd, rd_val, word;
  logic [AW-1:0]  data_ofs;
  logic [NEV-1:0] ist, ev;
  logic [CW-1:0]  idx;
  logic wide_q, seeded, busy, gen_done, seed_done, nonce, step, load, lockup, age, lfsr_lock;

  rng_seq #(
    .GEN_CYC(GEN_CYC), .SEED_CYC(SEED_CYC), .NWORDS(NWORDS), .AGE_LIMIT(AGE_LIMIT)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_we_i(wr_en_i && addr_i == OFS_CMD),
    .cmd_i(cmd_e'(wdata_i[1:0])),
    .wide_i(wide_q),
    .step_o(step), .load_o(load), .idx_o(idx),
    .gen_done_o(gen_done), .seed_done_o(seed_done), .nonce_o(nonce),
    .lockup_o(lockup), .age_o(age), .seeded_o(seeded), .busy_o(busy)
  );

  rng_lfsr #(.WORD_W(DW)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(step), .mix_i(seed_done), .nonce_i(nonce), .seed_i(seed_i),
    .word_o(word), .zero_o(lfsr_lock)
  );

  always_comb begin
    ev            = '0;
    ev[EV_RDY]    = gen_done;
    ev[EV_SEED]   = seed_done;
    ev[EV_AGE]    = age;
    ev[EV_REQLK]  = lockup;
    ev[EV_LFSRLK] = lfsr_lock;
  end

  rng_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ien_we_i(wr_en_i && addr_i == OFS_IEN),
    .ist_we_i(wr_en_i && addr_i == OFS_IST),
    .wdata_i(wdata_i), .ev_i(ev),
    .ien_o(ien_rd), .ist_o(ist), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wide_q <= 1'b0;
    else if (wr_en_i && addr_i == OFS_MODE) wide_q <= wdata_i[MODE_WIDE_BIT] & MAX_WIDE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NWORDS; k++) data_q[k] <= '0;
    end else begin
      for (int k = 0; k < NWORDS; k++)
        if (load && idx == CW'(k)) data_q[k] <= word;
    end
  end

  assign data_ofs = addr_i - OFS_DATA;

  always_comb begin
    rd_val = '0;
    if (addr_i == OFS_STAT)       rd_val[STAT_SEEDED_BIT] = seeded;
    else if (addr_i == OFS_MODE)  rd_val[MODE_WIDE_BIT]   = wide_q;
    else if (addr_i == OFS_IEN)   rd_val = ien_rd;
    else if (addr_i == OFS_IST)   rd_val = DW'(ist);
    else if (addr_i == OFS_FEAT)  rd_val = FEAT_WORD;
    else if (addr_i == OFS_BUILD) rd_val = BUILD_WORD;
    else if (addr_i >= OFS_DATA && data_ofs < AW'(4 * NWORDS) && data_ofs[1:0] == 2'b00)
      rd_val = data_q[data_ofs[IW+1:2]];
  end

  assign rdata_o = rd_en_i ? rd_val : '0;
endmodule

// File: rtl/rng_cmd_ctrl_chk.sv
module rng_cmd_ctrl_chk
  import rng_cmd_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [AW-1:0]  addr_i,
  input logic [1:0]     wdata_i,
  input logic           irq_o,
  input logic           ien_glob_i,
  input logic           seeded_i,
  input logic           busy_i,
  input logic [NEV-1:0] ist_i,
  input logic           gen_done_i
);
  logic cmd_we;
  assign cmd_we = wr_en_i && addr_i == OFS_CMD;

  a_r3_unseeded_gen_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && wdata_i == 2'd1 && !seeded_i && !busy_i) |=> ist_i[EV_REQLK]);

  a_r8_busy_cmd_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && wdata_i != 2'd0 && busy_i) |=> ist_i[EV_REQLK]);

  a_r4_seeded_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seeded_i |=> seeded_i);

  a_r5_rdy_after_gen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_done_i |=> ist_i[EV_RDY]);

  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_IST && wdata_i[0] && !gen_done_i) |=> !ist_i[EV_RDY]);

  a_r10_irq_needs_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_glob_i);
endmodule

bind rng_cmd_ctrl rng_cmd_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i[1:0]), .irq_o(irq_o), .ien_glob_i(ien_rd[31]),
  .seeded_i(seeded), .busy_i(busy), .ist_i(ist), .gen_done_i(gen_done)
);

// File: tb/rng_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module rng_cmd_ctrl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] seed = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_state = 64'h1;
  logic [31:0] m_data [8];
  int          m_age = 0;

  always #2.5 clk = ~clk;

  rng_cmd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .seed_i(seed), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic chk_reg(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, req, 64'(v), 64'(exp));
  endtask

  task automatic chk_words(input string req);
    for (int k = 0; k < 8; k++) chk_reg(8'h20 + 8'(4 * k), m_data[k], req);
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  task automatic do_reseed(input bit nonce, input logic [63:0] sd, output bit zero);
    logic [63:0] c;
    seed = sd;
    wr(8'h00, nonce ? 32'd3 : 32'd2);
    repeat (16) @(negedge clk);
    c = nonce ? sd : (m_state ^ sd);
    zero = (c == 64'h0);
    m_state = zero ? 64'h1 : c;
    m_age = 0;
  endtask

  task automatic do_gen(input bit wide);
    wr(8'h00, 32'd1);
    repeat (8) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      m_state = nxt(m_state);
      if (wide || k < 4) m_data[k] = m_state[63:32] ^ m_state[31:0];
    end
    m_age++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit z;
    for (int k = 0; k < 8; k++) m_data[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_reg(8'h04, 32'h0, "R1 status");
    chk_reg(8'h08, 32'h0, "R1 mode");
    chk_reg(8'h10, 32'h0, "R1 enable");
    chk_reg(8'h14, 32'h0, "R1 events");
    chk(irq == 1'b0, "R1 irq", 64'(irq), 64'h0);
    chk_words("R1 data");

    // R2 constant words
    chk_reg(8'h1C, 32'h0000000D, "R2 feature");
    chk_reg(8'h68, 32'h0000001C, "R2 build");

    // R13 command 0
    wr(8'h00, 32'd0);
    repeat (20) @(negedge clk);
    chk_reg(8'h14, 32'h0, "R13 nop events");
    chk_reg(8'h04, 32'h0, "R13 nop status");
    chk_words("R13 nop data");

    // R3 generate unseeded
    wr(8'h00, 32'd1);
    chk_reg(8'h14, 32'h8, "R3 lockup");
    repeat (10) @(negedge clk);
    chk_words("R3 data unchanged");
    chk_reg(8'h04, 32'h0, "R3 not seeded");

    // R9 write-1-to-clear: writing 0 keeps, writing 1 clears
    wr(8'h14, 32'h0);
    chk_reg(8'h14, 32'h8, "R9 zero write keeps");
    wr(8'h14, 32'hFFFF_FFFF);
    chk_reg(8'h14, 32'h0, "R9 all ones clears");

    // R4 reseed timing
    seed = 64'h0123_4567_89AB_CDEF;
    wr(8'h00, 32'd2);
    repeat (15) @(negedge clk);
    chk_reg(8'h04, 32'h0, "R4 not yet seeded at 15");
    @(negedge clk);
    chk_reg(8'h04, 32'h200, "R4 seeded at 16");
    chk_reg(8'h14, 32'h2, "R4 seed done");
    m_state = m_state ^ seed;
    m_age = 0;
    wr(8'h14, 32'h1F);

    // R5 generate timing, R6 content
    wr(8'h08, 32'h8);
    wr(8'h00, 32'd1);
    repeat (7) @(negedge clk);
    chk_reg(8'h14, 32'h0, "R5 not ready at 7");
    @(negedge clk);
    chk_reg(8'h14, 32'h1, "R5 ready at 8");
    for (int k = 0; k < 8; k++) begin
      m_state = nxt(m_state);
      m_data[k] = m_state[63:32] ^ m_state[31:0];
    end
    m_age++;
    chk_words("R6 first block");
    wr(8'h14, 32'h1F);

    // sweep: reseed kind, width, seeds (R4 R6 R7)
    for (int p = 0; p < 6; p++) begin
      bit wide = p[0];
      bit nonce = p[1];
      logic [63:0] sd = 64'h9E37_79B9_7F4A_7C15 * 64'(p + 3) ^ 64'(p);
      do_reseed(nonce, sd, z);
      wr(8'h08, wide ? 32'h8 : 32'h0);
      chk_reg(8'h08, wide ? 32'h8 : 32'h0, "R7 mode readback");
      do_gen(wide);
      chk_words(wide ? "R6 wide sweep" : "R7 narrow keeps upper words");
      chk_reg(8'h14, 32'h3, "R4 R5 events after sweep step");
      wr(8'h14, 32'h1F);
    end

    // R7 mode latched at accept: change mode during narrow generate
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h8);
    repeat (7) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      m_state = nxt(m_state);
      if (k < 4) m_data[k] = m_state[63:32] ^ m_state[31:0];
    end
    m_age++;
    chk_words("R7 mode latched");
    wr(8'h14, 32'h1F);

    // R8 command while busy
    seed = 64'hDEAD_BEEF_0BAD_F00D;
    wr(8'h00, 32'd1);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'd2);
    repeat (5) @(negedge clk);
    chk_reg(8'h14, 32'h9, "R8 ready plus lockup, no seed done");
    for (int k = 0; k < 8; k++) begin
      m_state = nxt(m_state);
      m_data[k] = m_state[63:32] ^ m_state[31:0];
    end
    m_age++;
    chk_words("R8 result unaffected");
    repeat (20) @(negedge clk);
    chk_reg(8'h14, 32'h9, "R8 dropped reseed never completes");
    wr(8'h14, 32'h1F);
    do_gen(1'b1);
    chk_words("R8 state not mixed");
    wr(8'h14, 32'h1F);

    // R10 interrupt gating, one pending source (bit 0)
    do_gen(1'b1);
    wr(8'h14, 32'h1E);
    chk_reg(8'h14, 32'h1, "R10 setup");
    wr(8'h10, 32'h0000_001F);
    chk(irq == 1'b0, "R10 no global", 64'(irq), 64'h0);
    wr(8'h10, 32'h8000_001E);
    chk(irq == 1'b0, "R10 source masked", 64'(irq), 64'h0);
    wr(8'h10, 32'h8000_0001);
    chk(irq == 1'b1, "R10 enabled pending", 64'(irq), 64'h1);
    chk_reg(8'h10, 32'h8000_0001, "R10 enable readback");
    wr(8'h10, 32'hFFFF_FFFF);
    chk_reg(8'h10, 32'h8000_001F, "R10 enable mask");
    wr(8'h14, 32'h1);
    chk(irq == 1'b0, "R10 cleared", 64'(irq), 64'h0);
    wr(8'h10, 32'h0);

    // R11 zero nonce
    do_reseed(1'b1, 64'h0, z);
    chk_reg(8'h14, 32'h12, "R11 lfsr lockup");
    wr(8'h14, 32'h1F);
    do_gen(1'b1);
    chk_words("R11 substitute state");
    wr(8'h14, 32'h1F);

    // R11 mix that cancels the state
    do_reseed(1'b0, m_state, z);
    chk(z == 1'b1, "R11 model zero", 64'(z), 64'h1);
    chk_reg(8'h14, 32'h12, "R11 mix zero lockup");
    wr(8'h14, 32'h1F);

    // R12 age alarm
    do_reseed(1'b0, 64'h5555_AAAA_3333_CCCC, z);
    wr(8'h14, 32'h1F);
    for (int g = 1; g <= 5; g++) begin
      do_gen(1'b1);
      rd(8'h14, v);
      chk(v[2] == (g == 4), "R12 age alarm", 64'(v[2]), 64'(g == 4));
      wr(8'h14, 32'h1F);
    end
    chk_words("R12 data");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule